// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block generates the datapath control signals for a multi-cycle processor core that handles register-register ALU operations, word loads and stores, branch-on-equal and unconditional jumps. It does not use a hand-written state-transition function. Instead it steps through a small internal microcode store. Each word in the store carries one full set of datapath controls and a 2-bit sequencing code. The sequencing code decides which word comes next.

A micro-address register selects the current word, and the store is read combinationally. An incrementer supplies the sequential successor of the current address. Address-select logic picks the next micro-address from four sources: the sequential address, a return to the fetch word, or one of two dispatch tables indexed by the opcode field of the instruction register. The first dispatch table, used after decode, sends each instruction class to its own routine. The second table, used after the memory address step, separates loads from stores. The surrounding core holds the opcode steady on the `opcode` input from the decode cycle onward.

Top module: `mpc_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the outputs present the fetch word. Reset is asynchronous and also takes effect in the middle of an instruction.
- R2: The fetch word asserts `mem_read`, `instr_load` and `pc_load` with `alu_b_sel`=01, `alu_mode`=00 (add) and `pc_next_sel`=00. All other controls are low. This word computes PC+4.
- R3: The cycle after fetch is always decode. In decode every write and memory enable is low, `alu_b_sel`=11 and `alu_mode`=00, whatever the opcode.
- R4: Opcode 6'b000000 (register type) runs exec for one cycle (`alu_a_reg`=1, `alu_b_sel`=00, `alu_mode`=10), then write-back (`rf_write`=1, `dest_from_rd`=1, `wb_from_mem`=0), then returns to fetch.
- R5: Opcode 6'b100011 (load) runs address (`alu_a_reg`=1, `alu_b_sel`=10, `alu_mode`=00), then read (`mem_read`=1, `mem_addr_from_alu`=1), then write-back (`rf_write`=1, `wb_from_mem`=1, `dest_from_rd`=0), then returns to fetch.
- R6: Opcode 6'b101011 (store) runs address, then write (`mem_write`=1, `mem_addr_from_alu`=1), then returns to fetch.
- R7: Opcode 6'b000100 (branch-on-equal) runs one compare cycle (`alu_a_reg`=1, `alu_b_sel`=00, `alu_mode`=01, `pc_load_if_zero`=1, `pc_next_sel`=01), then returns to fetch.
- R8: Opcode 6'b000010 (jump) runs one cycle with `pc_load`=1 and `pc_next_sel`=10, then returns to fetch.
- R9: Any opcode outside those five, seen in the decode cycle, sends the sequencer straight back to fetch after decode.
- R10: In the address cycle, an opcode that is neither load nor store sends the sequencer back to fetch on the next cycle.
- R11: The opcode is only consulted in the decode and address cycles. Its value in any other cycle does not change the outputs or the sequence that follows.
- R12: `mem_read` and `mem_write` are never both high, and `pc_load` and `pc_load_if_zero` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the micro-address advances on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to the fetch word |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_load | output | 1 | Unconditional program counter write |
| pc_load_if_zero | output | 1 | Program counter write when the ALU result is zero |
| mem_addr_from_alu | output | 1 | Memory address taken from the ALU result register rather than the PC |
| mem_read | output | 1 | Memory read enable |
| mem_write | output | 1 | Memory write enable |
| instr_load | output | 1 | Instruction register write |
| wb_from_mem | output | 1 | Register write data taken from the memory data register |
| dest_from_rd | output | 1 | Destination register taken from the rd field |
| rf_write | output | 1 | Register file write enable |
| alu_a_reg | output | 1 | ALU operand A taken from register A rather than the PC |
| alu_b_sel | output | 2 | ALU operand B: 00 reg B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_mode | output | 2 | ALU operation: 00 add, 01 subtract, 10 from function field |
| pc_next_sel | output | 2 | PC source: 00 ALU output, 01 ALU result register, 10 jump target |

## Verification
The hardest case to reach is a second dispatch that misses. The decode cycle must route a load or store into the address step, and then the opcode must change to something else in the very next cycle. A correct surrounding core never does this. The bench drives the opcode one cycle at a time, so it can swap in a different value exactly in the address cycle, both in directed cases and at random. In every cycle outside the two dispatch points it drives random or deliberately misleading opcodes, which shows that those values are ignored.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  localparam int OPC_W = 6;
  localparam int MC_AW = 4;

  typedef enum logic [1:0] {
    SQ_FETCH = 2'b00,
    SQ_DISP1 = 2'b01,
    SQ_DISP2 = 2'b10,
    SQ_NEXT  = 2'b11
  } seq_e;

  typedef struct packed {
    logic       pc_load;
    logic       pc_load_if_zero;
    logic       mem_addr_from_alu;
    logic       mem_read;
    logic       mem_write;
    logic       instr_load;
    logic       wb_from_mem;
    logic       dest_from_rd;
    logic       rf_write;
    logic       alu_a_reg;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_mode;
    logic [1:0] pc_next_sel;
  } ctl_t;

  typedef struct packed {
    ctl_t ctl;
    seq_e seq;
  } uword_t;

  typedef struct packed {
    logic             hit;
    logic [MC_AW-1:0] tgt;
  } disp_t;

  localparam logic [MC_AW-1:0] UA_FETCH  = 4'd0;
  localparam logic [MC_AW-1:0] UA_DECODE = 4'd1;
  localparam logic [MC_AW-1:0] UA_MADDR  = 4'd2;
  localparam logic [MC_AW-1:0] UA_LRD    = 4'd3;
  localparam logic [MC_AW-1:0] UA_LWB    = 4'd4;
  localparam logic [MC_AW-1:0] UA_SWR    = 4'd5;
  localparam logic [MC_AW-1:0] UA_REXE   = 4'd6;
  localparam logic [MC_AW-1:0] UA_RWB    = 4'd7;
  localparam logic [MC_AW-1:0] UA_BEQ    = 4'd8;
  localparam logic [MC_AW-1:0] UA_JMP    = 4'd9;

  localparam logic [OPC_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OP_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OP_JUMP  = 6'b000010;

  function automatic ctl_t ctl_idle();
    ctl_t c;
    c = '0;
    return c;
  endfunction

  // Microprogram contents, one word per micro-address.
  function automatic uword_t uword_at(input int unsigned a);
    uword_t w;
    w.ctl = ctl_idle();
    w.seq = SQ_FETCH;
    case (a)
      0: begin
        w.ctl.mem_read   = 1'b1;
        w.ctl.instr_load = 1'b1;
        w.ctl.pc_load    = 1'b1;
        w.ctl.alu_b_sel  = 2'b01;
        w.seq            = SQ_NEXT;
      end
      1: begin
        w.ctl.alu_b_sel = 2'b11;
        w.seq           = SQ_DISP1;
      end
      2: begin
        w.ctl.alu_a_reg = 1'b1;
        w.ctl.alu_b_sel = 2'b10;
        w.seq           = SQ_DISP2;
      end
      3: begin
        w.ctl.mem_read          = 1'b1;
        w.ctl.mem_addr_from_alu = 1'b1;
        w.seq                   = SQ_NEXT;
      end
      4: begin
        w.ctl.rf_write    = 1'b1;
        w.ctl.wb_from_mem = 1'b1;
      end
      5: begin
        w.ctl.mem_write         = 1'b1;
        w.ctl.mem_addr_from_alu = 1'b1;
      end
      6: begin
        w.ctl.alu_a_reg = 1'b1;
        w.ctl.alu_mode  = 2'b10;
        w.seq           = SQ_NEXT;
      end
      7: begin
        w.ctl.rf_write     = 1'b1;
        w.ctl.dest_from_rd = 1'b1;
      end
      8: begin
        w.ctl.alu_a_reg       = 1'b1;
        w.ctl.alu_mode        = 2'b01;
        w.ctl.pc_load_if_zero = 1'b1;
        w.ctl.pc_next_sel     = 2'b01;
      end
      9: begin
        w.ctl.pc_load     = 1'b1;
        w.ctl.pc_next_sel = 2'b10;
      end
      default: begin
        w.seq = SQ_FETCH;
      end
    endcase
    return w;
  endfunction

  // First dispatch: instruction class to routine entry.
  function automatic disp_t disp1_lookup(input logic [OPC_W-1:0] op);
    disp_t d;
    d.hit = 1'b1;
    case (op)
      OP_RTYPE:          d.tgt = UA_REXE;
      OP_LOAD, OP_STORE: d.tgt = UA_MADDR;
      OP_BEQ:            d.tgt = UA_BEQ;
      OP_JUMP:           d.tgt = UA_JMP;
      default: begin
        d.hit = 1'b0;
        d.tgt = UA_FETCH;
      end
    endcase
    return d;
  endfunction

  // Second dispatch: load versus store.
  function automatic disp_t disp2_lookup(input logic [OPC_W-1:0] op);
    disp_t d;
    d.hit = 1'b1;
    case (op)
      OP_LOAD:  d.tgt = UA_LRD;
      OP_STORE: d.tgt = UA_SWR;
      default: begin
        d.hit = 1'b0;
        d.tgt = UA_FETCH;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mpc_store.sv
module mpc_store
  import mpc_pkg::*;
#(
  parameter int UADDR_W = 4
) (
  input  logic [UADDR_W-1:0] upc,
  output uword_t             word
);

  localparam int DEPTH = 1 << UADDR_W;

  uword_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign rom[i] = uword_at(i);
  end

  assign word = rom[upc];

endmodule

// File: rtl/mpc_dispatch.sv
module mpc_dispatch
  import mpc_pkg::*;
#(
  parameter int UADDR_W = 4
) (
  input  logic [OPC_W-1:0]   opcode,
  output logic [UADDR_W-1:0] d1_tgt,
  output logic               d1_hit,
  output logic [UADDR_W-1:0] d2_tgt,
  output logic               d2_hit
);

  disp_t t1;
  disp_t t2;

  always_comb begin
    t1 = disp1_lookup(opcode);
    t2 = disp2_lookup(opcode);
  end

  assign d1_hit = t1.hit;
  assign d2_hit = t2.hit;
  assign d1_tgt = UADDR_W'(t1.tgt);
  assign d2_tgt = UADDR_W'(t2.tgt);

endmodule

// File: rtl/mpc_next.sv
module mpc_next
  import mpc_pkg::*;
#(
  parameter int UADDR_W = 4
) (
  input  logic [UADDR_W-1:0] upc,
  input  seq_e               seq,
  input  logic [UADDR_W-1:0] d1_tgt,
  input  logic [UADDR_W-1:0] d2_tgt,
  output logic [UADDR_W-1:0] upc_nxt
);

  function automatic logic [UADDR_W-1:0] step_up(input logic [UADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  logic [UADDR_W-1:0] upc_inc;
  assign upc_inc = step_up(upc);

  always_comb begin
    case (seq)
      SQ_NEXT:  upc_nxt = upc_inc;
      SQ_DISP1: upc_nxt = d1_tgt;
      SQ_DISP2: upc_nxt = d2_tgt;
      default:  upc_nxt = UADDR_W'(UA_FETCH);
    endcase
  end

endmodule

// File: rtl/mpc_sequencer.sv
module mpc_sequencer
  import mpc_pkg::*;
#(
  parameter int UADDR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       opcode,
  output logic             pc_load,
  output logic             pc_load_if_zero,
  output logic             mem_addr_from_alu,
  output logic             mem_read,
  output logic             mem_write,
  output logic             instr_load,
  output logic             wb_from_mem,
  output logic             dest_from_rd,
  output logic             rf_write,
  output logic             alu_a_reg,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_mode,
  output logic [1:0]       pc_next_sel
);

  logic [UADDR_W-1:0] upc_q;
  logic [UADDR_W-1:0] upc_d;
  uword_t             word;
  seq_e               seq_sel;
  logic [UADDR_W-1:0] d1_tgt;
  logic [UADDR_W-1:0] d2_tgt;
  logic               d1_hit;
  logic               d2_hit;

  mpc_store #(.UADDR_W(UADDR_W)) u_store (
    .upc  (upc_q),
    .word (word)
  );

  mpc_dispatch #(.UADDR_W(UADDR_W)) u_disp (
    .opcode (opcode),
    .d1_tgt (d1_tgt),
    .d1_hit (d1_hit),
    .d2_tgt (d2_tgt),
    .d2_hit (d2_hit)
  );

  assign seq_sel = word.seq;

  mpc_next #(.UADDR_W(UADDR_W)) u_next (
    .upc     (upc_q),
    .seq     (seq_sel),
    .d1_tgt  (d1_tgt),
    .d2_tgt  (d2_tgt),
    .upc_nxt (upc_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc_q <= '0;
    else        upc_q <= upc_d;
  end

  assign pc_load           = word.ctl.pc_load;
  assign pc_load_if_zero   = word.ctl.pc_load_if_zero;
  assign mem_addr_from_alu = word.ctl.mem_addr_from_alu;
  assign mem_read          = word.ctl.mem_read;
  assign mem_write         = word.ctl.mem_write;
  assign instr_load        = word.ctl.instr_load;
  assign wb_from_mem       = word.ctl.wb_from_mem;
  assign dest_from_rd      = word.ctl.dest_from_rd;
  assign rf_write          = word.ctl.rf_write;
  assign alu_a_reg         = word.ctl.alu_a_reg;
  assign alu_b_sel         = word.ctl.alu_b_sel;
  assign alu_mode          = word.ctl.alu_mode;
  assign pc_next_sel       = word.ctl.pc_next_sel;

endmodule

// File: rtl/mpc_sequencer_chk.sv
module mpc_sequencer_chk
  import mpc_pkg::*;
#(
  parameter int UADDR_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [5:0]         opcode,
  input logic [UADDR_W-1:0] upc,
  input seq_e               seq_sel,
  input logic               d1_hit,
  input logic               d2_hit,
  input logic               mem_read,
  input logic               mem_write,
  input logic               instr_load,
  input logic               pc_load,
  input logic               pc_load_if_zero
);

  p_reset_fetch_r1: assert property (@(posedge clk)
    !rst_n |=> (upc == UADDR_W'(UA_FETCH)));

  p_fetch_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UADDR_W'(UA_FETCH)) |-> (mem_read && instr_load && pc_load));

  p_fetch_to_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UADDR_W'(UA_FETCH)) |=> (upc == UADDR_W'(UA_DECODE)));

  p_rtype_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UADDR_W'(UA_DECODE) && opcode == OP_RTYPE) |=> (upc == UADDR_W'(UA_REXE)));

  p_load_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UADDR_W'(UA_MADDR) && opcode == OP_LOAD) |=> (upc == UADDR_W'(UA_LRD)));

  p_store_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UADDR_W'(UA_MADDR) && opcode == OP_STORE) |=> (upc == UADDR_W'(UA_SWR)));

  p_unknown_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_sel == SQ_DISP1 && !d1_hit) |=> (upc == UADDR_W'(UA_FETCH)));

  p_disp2_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_sel == SQ_DISP2 && !d2_hit) |=> (upc == UADDR_W'(UA_FETCH)));

  p_sequential_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_sel == SQ_NEXT) |=> (upc == UADDR_W'($past(upc) + 1'b1)));

  p_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_sel == SQ_FETCH) |=> (upc == UADDR_W'(UA_FETCH)));

  p_mem_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_read && mem_write));

  p_pc_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_load, pc_load_if_zero}));

endmodule

bind mpc_sequencer mpc_sequencer_chk #(.UADDR_W(UADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .opcode          (opcode),
  .upc             (upc_q),
  .seq_sel         (seq_sel),
  .d1_hit          (d1_hit),
  .d2_hit          (d2_hit),
  .mem_read        (mem_read),
  .mem_write       (mem_write),
  .instr_load      (instr_load),
  .pc_load         (pc_load),
  .pc_load_if_zero (pc_load_if_zero)
);

// File: tb/test_mpc_sequencer.sv
module test_mpc_sequencer;

  localparam int CLK_PERIOD = 10;

  localparam logic [5:0] T_R  = 6'b000000;
  localparam logic [5:0] T_LW = 6'b100011;
  localparam logic [5:0] T_SW = 6'b101011;
  localparam logic [5:0] T_BQ = 6'b000100;
  localparam logic [5:0] T_J  = 6'b000010;

  typedef enum int {
    S_F, S_D, S_RX, S_RWB, S_MA, S_LRD, S_LWB, S_SWR, S_BQ, S_J
  } step_e;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic       pc_load, pc_load_if_zero, mem_addr_from_alu, mem_read, mem_write;
  logic       instr_load, wb_from_mem, dest_from_rd, rf_write, alu_a_reg;
  logic [1:0] alu_b_sel, alu_mode, pc_next_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpc_sequencer i_mpc_sequencer (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
    .mem_addr_from_alu(mem_addr_from_alu), .mem_read(mem_read),
    .mem_write(mem_write), .instr_load(instr_load), .wb_from_mem(wb_from_mem),
    .dest_from_rd(dest_from_rd), .rf_write(rf_write), .alu_a_reg(alu_a_reg),
    .alu_b_sel(alu_b_sel), .alu_mode(alu_mode), .pc_next_sel(pc_next_sel)
  );

  wire [15:0] act = {pc_load, pc_load_if_zero, mem_addr_from_alu, mem_read, mem_write,
                     instr_load, wb_from_mem, dest_from_rd, rf_write, alu_a_reg,
                     alu_b_sel, alu_mode, pc_next_sel};

  // Order: pcl pcz adr rd wr ir wbm rd_dst rfw a b mode pcsel
  function automatic logic [15:0] mk(bit pcl, bit pcz, bit adr, bit rd, bit wr, bit ir,
                                     bit wbm, bit dst, bit rfw, bit a,
                                     logic [1:0] b, logic [1:0] m, logic [1:0] ps);
    return {pcl, pcz, adr, rd, wr, ir, wbm, dst, rfw, a, b, m, ps};
  endfunction

  function automatic logic [15:0] exp_ctl(step_e s);
    case (s)
      S_F:   return mk(1,0,0,1,0,1,0,0,0,0, 2'b01, 2'b00, 2'b00);
      S_D:   return mk(0,0,0,0,0,0,0,0,0,0, 2'b11, 2'b00, 2'b00);
      S_RX:  return mk(0,0,0,0,0,0,0,0,0,1, 2'b00, 2'b10, 2'b00);
      S_RWB: return mk(0,0,0,0,0,0,0,1,1,0, 2'b00, 2'b00, 2'b00);
      S_MA:  return mk(0,0,0,0,0,0,0,0,0,1, 2'b10, 2'b00, 2'b00);
      S_LRD: return mk(0,0,1,1,0,0,0,0,0,0, 2'b00, 2'b00, 2'b00);
      S_LWB: return mk(0,0,0,0,0,0,1,0,1,0, 2'b00, 2'b00, 2'b00);
      S_SWR: return mk(0,0,1,0,1,0,0,0,0,0, 2'b00, 2'b00, 2'b00);
      S_BQ:  return mk(0,1,0,0,0,0,0,0,0,1, 2'b00, 2'b01, 2'b01);
      default: return mk(1,0,0,0,0,0,0,0,0,0, 2'b00, 2'b00, 2'b10);
    endcase
  endfunction

  function automatic bit is_mem(logic [5:0] op);
    return (op == T_LW) || (op == T_SW);
  endfunction

  function automatic bit is_known(logic [5:0] op);
    return is_mem(op) || op == T_R || op == T_BQ || op == T_J;
  endfunction

  // Expected routine: op seen at decode, op2 seen at address step.
  function automatic int plan_len(logic [5:0] op, logic [5:0] op2);
    if (op == T_R) return 4;
    if (op == T_BQ || op == T_J) return 3;
    if (is_mem(op)) return (op2 == T_LW) ? 5 : (op2 == T_SW) ? 4 : 3;
    return 2;
  endfunction

  function automatic step_e plan_step(logic [5:0] op, logic [5:0] op2, int k);
    if (k == 0) return S_F;
    if (k == 1) return S_D;
    if (op == T_R) return (k == 2) ? S_RX : S_RWB;
    if (op == T_BQ) return S_BQ;
    if (op == T_J) return S_J;
    if (k == 2) return S_MA;
    if (op2 == T_SW) return S_SWR;
    return (k == 3) ? S_LRD : S_LWB;
  endfunction

  task automatic check_now(step_e s, string req);
    n_chk++;
    if (act !== exp_ctl(s)) begin
      n_bad++;
      $display("FAIL %s: controls=%h expected %h (step %0d)", req, act, exp_ctl(s), s);
    end
    n_chk++;
    if ((mem_read && mem_write) || (pc_load && pc_load_if_zero)) begin
      n_bad++;
      $display("FAIL R12: controls=%h expected no conflicting enables", act);
    end
  endtask

  // Entered at a negedge with the fetch word active; leaves likewise.
  task automatic run_instr(logic [5:0] op, logic [5:0] op2, logic [5:0] junk, string req);
    int len;
    len = plan_len(op, op2);
    for (int k = 0; k < len; k++) begin
      if (k == 1)                 opcode = op;
      else if (k == 2 && is_mem(op)) opcode = op2;
      else                        opcode = junk;
      #1;
      check_now(plan_step(op, op2, k), (k == 0) ? "R2" : (k == 1) ? "R3" : req);
      @(negedge clk);
    end
  endtask

  function automatic logic [5:0] pick_unknown();
    logic [5:0] v;
    v = 6'($urandom);
    while (is_known(v)) v = 6'($urandom);
    return v;
  endfunction

  initial begin
    void'($urandom(32'd20231104));
    rst_n = 1'b0;
    opcode = T_LW;
    repeat (2) @(negedge clk);
    #1 check_now(S_F, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    #1 check_now(S_F, "R1");

    run_instr(T_R,  T_R,  T_LW, "R4");
    run_instr(T_LW, T_LW, T_SW, "R5");
    run_instr(T_SW, T_SW, T_LW, "R6");
    run_instr(T_BQ, T_BQ, T_J,  "R7");
    run_instr(T_J,  T_J,  T_BQ, "R8");
    run_instr(6'b111111, 6'd0, T_R, "R9");
    run_instr(6'b001000, 6'd0, T_LW, "R9");
    run_instr(T_LW, T_R,  T_SW, "R10");
    run_instr(T_SW, T_BQ, T_LW, "R10");
    run_instr(T_LW, T_SW, T_R,  "R10");
    run_instr(T_R,  T_R,  T_SW, "R11");
    run_instr(T_BQ, T_BQ, T_LW, "R11");

    // R1: reset in the middle of an instruction.
    opcode = T_R; #1; check_now(S_F, "R2");
    @(negedge clk); #1; check_now(S_D, "R3");
    @(negedge clk); #1; check_now(S_RX, "R4");
    rst_n = 1'b0; #1; check_now(S_F, "R1");
    @(negedge clk); #1; check_now(S_F, "R1");
    rst_n = 1'b1; #1; check_now(S_F, "R1");

    for (int i = 0; i < 400; i++) begin
      logic [5:0] op, op2, junk;
      string r;
      int sel;
      sel = int'($urandom_range(0, 6));
      case (sel)
        0: begin op = T_R;  r = "R4"; end
        1: begin op = T_LW; r = "R5"; end
        2: begin op = T_SW; r = "R6"; end
        3: begin op = T_BQ; r = "R7"; end
        4: begin op = T_J;  r = "R8"; end
        5: begin op = pick_unknown(); r = "R9"; end
        default: begin op = ($urandom_range(0, 1) != 0) ? T_LW : T_SW; r = "R10"; end
      endcase
      op2 = op;
      if (sel == 6) op2 = ($urandom_range(0, 2) == 0) ? pick_unknown() :
                          ($urandom_range(0, 1) != 0) ? T_LW : T_SW;
      junk = 6'($urandom);
      run_instr(op, op2, junk, r);
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule